// File: doc/BRIEF.md
# Ramp-Step ADC Averaging Self-Test Sequencer

This block runs a transfer-curve self-test of an 8-bit analog-to-digital converter. It drives a ramp code to an external linear ramp source, one code per step, from zero up to the all-ones code. With the default 12-bit code this gives a 4096-step sweep. At every step it waits for the converter's output to settle and then sums a fixed number of consecutive conversion words. The number of words is 64 or 128, chosen when the sweep starts. The rounded mean of those words is written into a byte-wide result memory at the address equal to the current ramp code.

The memory then holds the captured transfer curve, which can be used for offset, gain, linearity and missing-code analysis. The block reads that memory back as a bit stream. A load pulse selects a start address. Each shift pulse moves one bit out, most significant bit first, and the address advances by itself after every eight bits. The converter, the ramp source and the memory array itself sit outside the block.

Top module: `ramp_bist_ctrl`

## Requirements
- R1: After reset, busy, done and the memory write strobe are low, the ramp code is zero and the serial output is low.
- R2: A start pulse while idle raises busy on the next cycle with the ramp code at zero. The code then steps up by one after each result write, and each step's result is written exactly once, at the address equal to that step's ramp code.
- R3: At the start of every step the block discards the first S valid samples, where S is the settle count captured at start. When S is zero, no sample is discarded.
- R4: The written byte is the mean of the next N valid samples, rounded half up: (sum + N/2) / N. N is 64 when the average-select input is 0 at start and 128 when it is 1. Cycles with the valid strobe low add nothing.
- R5: The memory write strobe is high for exactly one cycle, the cycle right after the edge that took the step's last averaged sample.
- R6: One cycle after the write for the all-ones code, done pulses high for a single cycle and busy is low.
- R7: A start pulse while busy has no effect: the sweep keeps its ramp code and its settings.
- R8: An abort pulse returns the block to idle on the next cycle without a done pulse, and no further writes happen.
- R9: A read-load pulse (while idle) loads the byte at the given address. Its bit 7 appears on the serial output on the next cycle. Each shift pulse presents the next lower bit. After eight shifts the byte at the following address (wrapping) is presented from its bit 7.
- R10: Read-load and shift pulses are ignored while busy, so the serial state after the sweep is the state from before it.
- R11: Changes to the average-select and settle-count inputs during a sweep have no effect on that sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a sweep (idle only) |
| abort_i | input | 1 | Cancel the sweep, return to idle |
| avg_hi_i | input | 1 | 0: average 64 samples, 1: average 128 |
| settle_i | input | SETTLE_W | Samples discarded after each code change |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle pulse after the last step is written |
| ramp_code_o | output | CODE_W | Code for the external ramp source |
| smp_valid_i | input | 1 | Converter word strobe |
| smp_data_i | input | SAMPLE_W | Converter output word |
| mem_we_o | output | 1 | Result write strobe |
| mem_addr_o | output | CODE_W | Result write address |
| mem_wdata_o | output | SAMPLE_W | Rounded mean |
| mem_raddr_o | output | CODE_W | Result memory read address (asynchronous read) |
| mem_rdata_i | input | SAMPLE_W | Result memory read data |
| rd_load_i | input | 1 | Load the readout start address |
| rd_addr_i | input | CODE_W | Readout start address |
| rd_shift_i | input | 1 | Advance the serial output by one bit |
| rd_ser_o | output | 1 | Serial result bit |

## Verification
Busy and a zero ramp code are due one cycle after start. A write is due in the cycle after the edge that took a step's final averaged sample, and the next code, or done, is due the cycle after that. The stimulus task drives samples on falling edges with a one-cycle low gap after each valid strobe, so every step ends at a known falling edge, where the bench compares the code and done. A scoreboard queue holds the expected address and mean and is compared on every falling edge that sees the write strobe. The abort response and each serial bit are checked one cycle after the pulse that causes them.

// File: rtl/ramp_bist_pkg.sv
package ramp_bist_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_ACCUM  = 2'd2,
        ST_WRITE  = 2'd3
    } bist_state_e;

endpackage

// File: rtl/rbc_mean.sv
// Rounded mean of a power-of-two sample count: (sum + half) >> log2(count).
module rbc_mean #(
    parameter int ACC_W      = 15,
    parameter int SAMPLE_W   = 8,
    parameter int LOG_AVG_LO = 6,
    parameter int LOG_AVG_HI = 7
) (
    input  logic [ACC_W-1:0]    acc_i,
    input  logic                hi_i,
    output logic [SAMPLE_W-1:0] mean_o
);
    localparam int RND_W = ACC_W + 1;
    localparam logic [RND_W-1:0] HALF_LO = RND_W'(2 ** (LOG_AVG_LO - 1));
    localparam logic [RND_W-1:0] HALF_HI = RND_W'(2 ** (LOG_AVG_HI - 1));

    logic [RND_W-1:0] rnd_lo, rnd_hi, sh_lo, sh_hi;

    always_comb begin
        rnd_lo = {1'b0, acc_i} + HALF_LO;
        rnd_hi = {1'b0, acc_i} + HALF_HI;
        sh_lo  = rnd_lo >> LOG_AVG_LO;
        sh_hi  = rnd_hi >> LOG_AVG_HI;
        mean_o = hi_i ? SAMPLE_W'(sh_hi) : SAMPLE_W'(sh_lo);
    end
endmodule

// File: rtl/rbc_shift.sv
// Byte-wide parallel-to-serial readout with auto-incrementing address.
module rbc_shift #(
    parameter int CODE_W = 12,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              load_i,
    input  logic [CODE_W-1:0] start_addr_i,
    input  logic              shift_i,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic [CODE_W-1:0] raddr_o,
    output logic              ser_o
);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [CODE_W-1:0] ptr;
        logic [BIT_W-1:0]  bits;
        logic [BYTE_W-1:0] sreg;
    } shift_t;

    shift_t shift_d, shift_q;

    always_comb begin
        shift_d = shift_q;
        raddr_o = shift_q.ptr + CODE_W'(1);
        if (en_i && load_i) begin
            raddr_o       = start_addr_i;
            shift_d.ptr   = start_addr_i;
            shift_d.bits  = '0;
            shift_d.sreg  = rdata_i;
        end else if (en_i && shift_i) begin
            if (shift_q.bits == LAST_BIT) begin
                shift_d.ptr  = shift_q.ptr + CODE_W'(1);
                shift_d.bits = '0;
                shift_d.sreg = rdata_i;
            end else begin
                shift_d.bits = shift_q.bits + BIT_W'(1);
                shift_d.sreg = shift_q.sreg << 1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= shift_d;
    end

    assign ser_o = shift_q.sreg[BYTE_W-1];
endmodule

// File: rtl/ramp_bist_ctrl.sv
module ramp_bist_ctrl
    import ramp_bist_pkg::*;
#(
    parameter int CODE_W     = 12,
    parameter int SAMPLE_W   = 8,
    parameter int SETTLE_W   = 4,
    parameter int LOG_AVG_LO = 6,
    parameter int LOG_AVG_HI = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                abort_i,
    input  logic                avg_hi_i,
    input  logic [SETTLE_W-1:0] settle_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [CODE_W-1:0]   ramp_code_o,
    input  logic                smp_valid_i,
    input  logic [SAMPLE_W-1:0] smp_data_i,
    output logic                mem_we_o,
    output logic [CODE_W-1:0]   mem_addr_o,
    output logic [SAMPLE_W-1:0] mem_wdata_o,
    output logic [CODE_W-1:0]   mem_raddr_o,
    input  logic [SAMPLE_W-1:0] mem_rdata_i,
    input  logic                rd_load_i,
    input  logic [CODE_W-1:0]   rd_addr_i,
    input  logic                rd_shift_i,
    output logic                rd_ser_o
);
    localparam int ACC_W = SAMPLE_W + LOG_AVG_HI;
    localparam int CNT_W = LOG_AVG_HI + 1;
    localparam logic [CNT_W-1:0]  LAST_LO   = CNT_W'(2 ** LOG_AVG_LO - 1);
    localparam logic [CNT_W-1:0]  LAST_HI   = CNT_W'(2 ** LOG_AVG_HI - 1);
    localparam logic [CODE_W-1:0] LAST_CODE = '1;

    typedef struct packed {
        bist_state_e         st;
        logic [CODE_W-1:0]   code;
        logic [ACC_W-1:0]    acc;
        logic [CNT_W-1:0]    cnt;
        logic [SETTLE_W-1:0] scnt;
        logic [SETTLE_W-1:0] settle;
        logic                hi;
        logic                done;
    } core_t;

    core_t core_d, core_q;
    logic [CNT_W-1:0] last_idx;

    always_comb begin
        core_d      = core_q;
        core_d.done = 1'b0;
        last_idx    = core_q.hi ? LAST_HI : LAST_LO;
        unique case (core_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    core_d.st     = (settle_i == '0) ? ST_ACCUM : ST_SETTLE;
                    core_d.code   = '0;
                    core_d.acc    = '0;
                    core_d.cnt    = '0;
                    core_d.scnt   = '0;
                    core_d.settle = settle_i;
                    core_d.hi     = avg_hi_i;
                end
            end
            ST_SETTLE: begin
                if (smp_valid_i) begin
                    if (core_q.scnt == core_q.settle - SETTLE_W'(1)) begin
                        core_d.st   = ST_ACCUM;
                        core_d.scnt = '0;
                    end else begin
                        core_d.scnt = core_q.scnt + SETTLE_W'(1);
                    end
                end
            end
            ST_ACCUM: begin
                if (smp_valid_i) begin
                    core_d.acc = core_q.acc + ACC_W'(smp_data_i);
                    core_d.cnt = core_q.cnt + CNT_W'(1);
                    if (core_q.cnt == last_idx) core_d.st = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (core_q.code == LAST_CODE) begin
                    core_d.st   = ST_IDLE;
                    core_d.done = 1'b1;
                end else begin
                    core_d.code = core_q.code + CODE_W'(1);
                    core_d.acc  = '0;
                    core_d.cnt  = '0;
                    core_d.scnt = '0;
                    core_d.st   = (core_q.settle == '0) ? ST_ACCUM : ST_SETTLE;
                end
            end
            default: core_d.st = ST_IDLE;
        endcase
        if (abort_i) begin
            core_d.st   = ST_IDLE;
            core_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign busy_o      = (core_q.st != ST_IDLE);
    assign done_o      = core_q.done;
    assign ramp_code_o = core_q.code;
    assign mem_we_o    = (core_q.st == ST_WRITE) && !abort_i;
    assign mem_addr_o  = core_q.code;

    rbc_mean #(
        .ACC_W     (ACC_W),
        .SAMPLE_W  (SAMPLE_W),
        .LOG_AVG_LO(LOG_AVG_LO),
        .LOG_AVG_HI(LOG_AVG_HI)
    ) u_mean (
        .acc_i (core_q.acc),
        .hi_i  (core_q.hi),
        .mean_o(mem_wdata_o)
    );

    rbc_shift #(
        .CODE_W(CODE_W),
        .BYTE_W(SAMPLE_W)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (!busy_o),
        .load_i      (rd_load_i),
        .start_addr_i(rd_addr_i),
        .shift_i     (rd_shift_i),
        .rdata_i     (mem_rdata_i),
        .raddr_o     (mem_raddr_o),
        .ser_o       (rd_ser_o)
    );
endmodule

// File: rtl/ramp_bist_ctrl_chk.sv
module ramp_bist_ctrl_chk #(
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              abort_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [CODE_W-1:0] ramp_code_o,
    input logic              mem_we_o,
    input logic [CODE_W-1:0] mem_addr_o
);
    localparam logic [CODE_W-1:0] LAST_CODE = '1;

    p_we_in_sweep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);

    p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(mem_we_o) && ($past(mem_addr_o) == LAST_CODE)));

    p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!busy_o && !done_o));

    p_code_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !mem_we_o) |=> $stable(ramp_code_o));

    p_code_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && (mem_addr_o != LAST_CODE)) |=>
            (ramp_code_o == CODE_W'($past(ramp_code_o) + 1'b1)));

    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !abort_i && !mem_we_o) |=> busy_o);
endmodule

bind ramp_bist_ctrl ramp_bist_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .abort_i    (abort_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .ramp_code_o(ramp_code_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o)
);

// File: tb/ramp_bist_ctrl_test.sv
module ramp_bist_ctrl_test;
    localparam int CW    = 3;
    localparam int NSTEP = 2 ** CW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, abort_i = 1'b0, avg_hi_i = 1'b0;
    logic [3:0] settle_i = 4'd4;
    logic smp_valid_i = 1'b0;
    logic [7:0] smp_data_i = 8'd0;
    logic rd_load_i = 1'b0, rd_shift_i = 1'b0;
    logic [CW-1:0] rd_addr_i = '0;
    logic busy_o, done_o, mem_we_o, rd_ser_o;
    logic [CW-1:0] ramp_code_o, mem_addr_o, mem_raddr_o;
    logic [7:0] mem_wdata_o, mem_rdata_i;

    logic [7:0] mem [NSTEP];
    logic [7:0] exp_mem [NSTEP];
    logic [CW+7:0] exp_q [$];

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    ramp_bist_ctrl #(.CODE_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
        .avg_hi_i(avg_hi_i), .settle_i(settle_i), .busy_o(busy_o), .done_o(done_o),
        .ramp_code_o(ramp_code_o), .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_raddr_o(mem_raddr_o), .mem_rdata_i(mem_rdata_i), .rd_load_i(rd_load_i),
        .rd_addr_i(rd_addr_i), .rd_shift_i(rd_shift_i), .rd_ser_o(rd_ser_o)
    );

    assign mem_rdata_i = mem[mem_raddr_o];

    initial for (int k = 0; k < NSTEP; k++) begin mem[k] = 8'd0; exp_mem[k] = 8'd0; end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && mem_we_o) begin
            mem[mem_addr_o] <= mem_wdata_o;
            if (exp_q.size() == 0) begin
                chk("R8 write with nothing expected", 1, 0);
            end else begin
                logic [CW+7:0] e;
                e = exp_q.pop_front();
                chk("R2 write address", int'(mem_addr_o), int'(e[CW+7:8]));
                chk("R4 rounded mean", int'(mem_wdata_o), int'(e[7:0]));
            end
        end
    end

    function automatic int smp(input int pat, input int c, input int i, input int n);
        case (pat)
            0: return (c * 37 + i * 13 + 5) % 256;
            1: return (i < n / 2) ? 1 : 0;
            2: return 255;
            default: return (i % 2 == 1) ? 200 : 10;
        endcase
    endfunction

    task automatic drive(input int v, input bit extra_gap);
        smp_valid_i = 1'b1;
        smp_data_i  = 8'(v);
        @(negedge clk);
        smp_valid_i = 1'b0;
        smp_data_i  = 8'd0;
        @(negedge clk);
        if (extra_gap) @(negedge clk);
    endtask

    task automatic run_sweep(input bit hi, input int settle, input bit poke);
        int n;
        int sum;
        int v;
        n = hi ? 128 : 64;
        @(negedge clk);
        start_i = 1'b1; avg_hi_i = hi; settle_i = 4'(settle);
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 busy after start", int'(busy_o), 1);
        for (int c = 0; c < NSTEP; c++) begin
            chk("R2 ramp code per step", int'(ramp_code_o), c);
            if (poke && c == 3) begin
                // R7 / R11: start and setting changes mid-sweep
                start_i = 1'b1; avg_hi_i = ~hi; settle_i = 4'd0;
                @(negedge clk);
                start_i = 1'b0;
                chk("R7 code kept after start while busy", int'(ramp_code_o), c);
                chk("R7 still busy", int'(busy_o), 1);
            end
            for (int s = 0; s < settle; s++) drive(250, s == 1);   // R3 discarded
            sum = 0;
            for (int i = 0; i < n; i++) begin
                v = smp(c % 4, c, i, n);
                sum += v;
                if (i == n - 1) begin
                    exp_mem[c] = 8'((sum + n / 2) / n);
                    exp_q.push_back({CW'(c), exp_mem[c]});
                end
                drive(v, (i % 5 == 2) && (i != n - 1));
            end
        end
        chk("R6 done pulse after last write", int'(done_o), 1);
        chk("R6 busy low at done", int'(busy_o), 0);
        @(negedge clk);
        chk("R6 done is one cycle", int'(done_o), 0);
        chk("R5 all expected writes seen", exp_q.size(), 0);
    endtask

    task automatic rd_load(input int a);
        rd_addr_i = CW'(a);
        rd_load_i = 1'b1;
        @(negedge clk);
        rd_load_i = 1'b0;
    endtask

    task automatic rd_bits(input int nb, output logic [15:0] v);
        v = '0;
        for (int b = 0; b < nb; b++) begin
            v = {v[14:0], rd_ser_o};
            rd_shift_i = 1'b1;
            @(negedge clk);
            rd_shift_i = 1'b0;
        end
    endtask

    initial begin
        logic [15:0] got;
        logic [7:0] old0;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", int'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 write strobe", int'(mem_we_o), 0);
        chk("R1 ramp code", int'(ramp_code_o), 0);
        chk("R1 serial out", int'(rd_ser_o), 0);

        // R3 settle 4, R4 average 64
        run_sweep(1'b0, 4, 1'b0);

        // R9 readout with auto-increment and wrap
        rd_load(2);
        rd_bits(16, got);
        chk("R9 serial bytes 2,3", int'(got), int'({exp_mem[2], exp_mem[3]}));
        rd_load(NSTEP - 1);
        rd_bits(16, got);
        chk("R9 serial wrap last,0", int'(got), int'({exp_mem[NSTEP-1], exp_mem[0]}));

        // R3 settle 0, R4 average 128
        run_sweep(1'b1, 0, 1'b0);

        // R10: partial readout, then readout pulses while busy
        rd_load(0);
        rd_bits(3, got);
        old0 = exp_mem[0];
        fork
            run_sweep(1'b1, 2, 1'b1);   // R7, R11
            begin
                repeat (60) @(negedge clk);
                rd_addr_i = CW'(5);
                rd_load_i = 1'b1;
                @(negedge clk);
                rd_load_i = 1'b0;
                rd_shift_i = 1'b1;
                repeat (4) @(negedge clk);
                rd_shift_i = 1'b0;
            end
        join
        rd_bits(5, got);
        chk("R10 serial state kept across busy", int'(got[4:0]), int'(old0[4:0]));

        // R8 abort mid-step
        @(negedge clk);
        start_i = 1'b1; avg_hi_i = 1'b0; settle_i = 4'd4;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 20; i++) drive(i, 1'b0);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        chk("R8 busy low after abort", int'(busy_o), 0);
        chk("R8 no done after abort", int'(done_o), 0);
        for (int i = 0; i < 80; i++) drive(100, 1'b0);
        chk("R8 still idle", int'(busy_o), 0);
        chk("R8 no writes pending", exp_q.size(), 0);

        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_up();
    end
endmodule